// File: doc/BRIEF.md
# Atomic Lock Output Generator

This block follows a PCI master's locked (atomic) sequence and drives an active-low lock indication onto the local bus. It samples the PCI frame and lock signals on each clock. It also samples a decode input that says whether the current access targets the lockable local window. That window is address space 0, address space 1 and the expansion ROM, all treated as one. When an enabled, locked access begins, the local lock output goes active and stays active through every access the owning master makes. It releases only when the PCI master ends the lock.

While the lock is held, an access that enters the lockable window from a master that does not own the lock is flagged for retry. A master abort of the access that opened the lock cancels the lock. A configuration enable gates the whole feature. External arbitration logic watches the lock output and enforces exclusivity. That logic is not part of this block.

All PCI inputs are active low. An address clock is a clock edge at which `frame_n` is sampled low after it was sampled high at the previous edge.

Top module: `atomic_lock_drive`

## Requirements
- R1: During reset and after it ends, with no locked access seen, `lock_o_n` is 1 and `retry_o` is 0.
- R2: At an address clock where `lock_n` is 0, `region_hit` is 1, `lock_en` is 1 and no lock is held, a lock is taken. `lock_o_n` is 0 from the clock after that edge.
- R3: An address clock with `lock_n` 1, or with `region_hit` 0, takes no lock.
- R4: While `lock_en` is 0, no lock is taken. Dropping `lock_en` while a lock is held sets `lock_o_n` to 1 one clock later.
- R5: An address clock at which `lock_n` is 1 while a lock is held is an access by the owner. It leaves the lock in place.
- R6: A held lock is released at an edge where `frame_n` and `lock_n` are both sampled 1 and `frame_n` was also 1 at the previous edge. `lock_o_n` is 1 from the next clock, so release comes at least one clock after the last access ends.
- R7: A held lock is kept whenever `lock_n` is 0, or `frame_n` is 0, at an edge.
- R8: While a lock is held, an address clock with `lock_n` 0 and `region_hit` 1 drives `retry_o` to 1 in that same cycle, and the lock is unchanged.
- R9: `master_abort` at an edge before the owner's second access clears the lock, and `lock_o_n` is 1 on the next clock. After the owner's second address clock, `master_abort` has no effect on the lock.
- R10: `retry_o` is 0 whenever no lock is held, and also at an address clock where `region_hit` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PCI clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lock_en | input | 1 | Configuration enable for locked accesses to the local bus |
| frame_n | input | 1 | PCI FRAME#, active low |
| lock_n | input | 1 | PCI LOCK#, active low |
| region_hit | input | 1 | Access decodes to the lockable local window |
| master_abort | input | 1 | Current access ended by master abort |
| lock_o_n | output | 1 | Registered local lock output, active low |
| retry_o | output | 1 | Answer the current address clock with retry |

## Verification
`lock_o_n` is a register, so it changes one clock after the edge that samples the event that takes, drops or cancels the lock. `retry_o` depends on the held state and on the current inputs, so it is valid in the same cycle as the address clock that causes it. The bench drives inputs on the falling edge and compares both outputs with its reference model 5 ns before the next rising edge. The model updates its own state on that same rising edge, so each expected value is due in exactly the cycle described above.

// File: rtl/atomic_lock_drive.sv
module atomic_lock_drive (
  input  logic clk,
  input  logic rst_n,
  input  logic lock_en,
  input  logic frame_n,
  input  logic lock_n,
  input  logic region_hit,
  input  logic master_abort,
  output logic lock_o_n,
  output logic retry_o
);

  logic held_q, first_q, frame_q;

  logic addr_clk, take, owner_acc, abort_clr, release_ok;

  assign addr_clk   = !frame_n && frame_q;
  assign take       = !held_q && lock_en && addr_clk && !lock_n && region_hit;
  assign owner_acc  = held_q && addr_clk && lock_n;
  assign abort_clr  = held_q && first_q && master_abort;
  assign release_ok = held_q && frame_n && frame_q && lock_n;

  assign retry_o  = held_q && addr_clk && !lock_n && region_hit;
  assign lock_o_n = !held_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held_q  <= 1'b0;
      first_q <= 1'b0;
      frame_q <= 1'b1;
    end else begin
      frame_q <= frame_n;
      if (!lock_en || abort_clr || release_ok) begin
        held_q  <= 1'b0;
        first_q <= 1'b0;
      end else if (take) begin
        held_q  <= 1'b1;
        first_q <= 1'b1;
      end else if (owner_acc) begin
        first_q <= 1'b0;
      end
    end
  end

endmodule

module atomic_lock_drive_chk (
  input logic clk,
  input logic rst_n,
  input logic lock_en,
  input logic frame_n,
  input logic lock_n,
  input logic region_hit,
  input logic master_abort,
  input logic lock_o_n,
  input logic retry_o
);

  logic fr_d;
  always_ff @(posedge clk) begin
    if (!rst_n) fr_d <= 1'b1;
    else        fr_d <= frame_n;
  end

  // R2
  acquire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock_o_n && lock_en && !frame_n && fr_d && !lock_n && region_hit |=> !lock_o_n);

  // R4
  disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lock_en |=> lock_o_n);

  // R7
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lock_o_n && lock_en && !master_abort && (!lock_n || !frame_n) |=> !lock_o_n);

  // R6
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_o_n) |-> $past(!lock_en || master_abort || (frame_n && lock_n)));

  // R8
  retry_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    retry_o && lock_en |=> !lock_o_n);

  // R10
  retry_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    retry_o |-> !lock_o_n && region_hit);

endmodule

bind atomic_lock_drive atomic_lock_drive_chk chk_i (
  .clk(clk), .rst_n(rst_n), .lock_en(lock_en), .frame_n(frame_n),
  .lock_n(lock_n), .region_hit(region_hit), .master_abort(master_abort),
  .lock_o_n(lock_o_n), .retry_o(retry_o)
);

// File: tb/atomic_lock_drive_tb_top.sv
module atomic_lock_drive_tb_top;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lock_en = 1'b1, frame_n = 1'b1, lock_n = 1'b1, region_hit = 1'b0, master_abort = 1'b0;
  logic lock_o_n, retry_o;

  always #10 clk = ~clk;

  atomic_lock_drive dut_i (
    .clk(clk), .rst_n(rst_n), .lock_en(lock_en), .frame_n(frame_n),
    .lock_n(lock_n), .region_hit(region_hit), .master_abort(master_abort),
    .lock_o_n(lock_o_n), .retry_o(retry_o)
  );

  int checks = 0, fails = 0;
  string tag = "R1";

  // reference model: frame history queue plus ownership counters
  bit fr_hist[$];
  int owned = 0;
  int owner_accesses = 0;

  function automatic bit is_addr_clk();
    return (frame_n == 1'b0) && (fr_hist.size() > 0) && (fr_hist[$] == 1'b1);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      owned = 0; owner_accesses = 0;
      fr_hist.delete();
      fr_hist.push_back(1'b1);
    end else begin
      bit ac;
      bit prev_fr;
      ac = is_addr_clk();
      prev_fr = fr_hist[$];
      if (owned != 0) begin
        if (lock_en == 1'b0) owned = 0;
        else if (master_abort && owner_accesses == 0) owned = 0;
        else if (frame_n && lock_n && prev_fr) owned = 0;
        else if (ac && lock_n) owner_accesses++;
      end else if (lock_en && ac && !lock_n && region_hit) begin
        owned = 1; owner_accesses = 0;
      end
      fr_hist.push_back(frame_n);
      if (fr_hist.size() > 4) void'(fr_hist.pop_front());
    end
  end

  task automatic check1(string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic step(logic f, logic l, logic h, logic e, logic a);
    @(negedge clk);
    frame_n = f; lock_n = l; region_hit = h; lock_en = e; master_abort = a;
    #5;
    check1("lock_o_n", lock_o_n, (owned != 0) ? 1'b0 : 1'b1);
    check1("retry_o", retry_o,
           ((owned != 0) && rst_n && is_addr_clk() && !lock_n && region_hit) ? 1'b1 : 1'b0);
  endtask

  initial begin
    #3000000;
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    tag = "R1";
    repeat (3) step(1, 1, 0, 1, 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (2) step(1, 1, 0, 1, 0);

    tag = "R3";
    step(0, 1, 1, 1, 0); step(1, 1, 1, 1, 0);
    step(0, 0, 0, 1, 0); step(1, 1, 0, 1, 0); step(1, 1, 0, 1, 0);

    tag = "R10";
    step(0, 0, 1, 0, 0); step(1, 1, 1, 1, 0);

    tag = "R2";
    step(0, 0, 1, 1, 0); step(0, 0, 1, 1, 0);
    tag = "R7";
    step(1, 0, 1, 1, 0); step(1, 0, 0, 1, 0);
    tag = "R5";
    step(0, 1, 1, 1, 0); step(0, 0, 1, 1, 0); step(1, 0, 1, 1, 0);
    tag = "R8";
    step(0, 0, 1, 1, 0); step(1, 0, 1, 1, 0);
    tag = "R10";
    step(0, 0, 0, 1, 0); step(1, 0, 0, 1, 0);
    tag = "R6";
    step(0, 1, 1, 1, 0); step(1, 1, 1, 1, 0); step(1, 1, 1, 1, 0); step(1, 1, 1, 1, 0);

    tag = "R9";
    step(0, 0, 1, 1, 0); step(1, 0, 1, 1, 1); step(1, 0, 1, 1, 0); step(1, 1, 1, 1, 0);
    step(0, 0, 1, 1, 0); step(1, 0, 1, 1, 0);
    step(0, 1, 1, 1, 0); step(1, 0, 1, 1, 0);
    step(0, 1, 1, 1, 0); step(1, 0, 1, 1, 1); step(1, 0, 1, 1, 0);
    tag = "R6";
    step(1, 1, 1, 1, 0); step(1, 1, 1, 1, 0);

    tag = "R4";
    step(0, 0, 1, 0, 0); step(1, 0, 1, 0, 0); step(1, 1, 1, 1, 0);
    step(0, 0, 1, 1, 0); step(1, 0, 1, 1, 0); step(1, 0, 1, 0, 0); step(1, 0, 1, 0, 0);
    step(1, 1, 1, 1, 0);

    tag = "R8";
    step(0, 0, 1, 1, 0); step(1, 0, 1, 1, 0); step(0, 0, 1, 1, 0); step(0, 0, 1, 1, 0);
    tag = "R6";
    step(1, 1, 1, 1, 0); step(1, 1, 1, 1, 0); step(1, 1, 1, 1, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule